// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This unit is the multiply and divide side of an integer core. It owns the 64-bit result pair: HI holds the upper word and LO the lower word. Command slots arrive as a one-cycle strobe. Each command carries a group select, a 6-bit function code and two operands, `rs_val` and `rt_val`.

In the primary group the unit runs signed or unsigned multiply and divide, and moves a word into or out of HI or LO. In the secondary group it adds or subtracts a product to or from the HI:LO pair. It also has a three-operand multiply that returns only the low product word and leaves HI and LO untouched.

Multiplies and accumulates finish in one clock. Divides run on a restoring divider that produces one quotient bit per cycle, and `busy` is raised for the whole divide. While `busy` is high, reads of HI or LO wait and are answered once the new values are in place. Every other command issued while `busy` is high is dropped.

Top module: `hilo_muldiv`

## Requirements
- R1: After a synchronous reset, HI and LO read as zero, and `busy`, `rd_valid` and `mul_valid` are all low.
- R2: In the primary group (`op_alt`=0), function 0x11 loads HI from `rs_val` and 0x13 loads LO from `rs_val`. Function 0x10 returns HI and 0x12 returns LO on `rd_data`, with `rd_valid` high in the cycle after the command.
- R3: Primary functions 0x18 (signed) and 0x19 (unsigned) multiply `rs_val` by `rt_val`. Product bits 63:32 go to HI and bits 31:0 go to LO, visible from the next cycle.
- R4: Primary functions 0x1A (signed) and 0x1B (unsigned) divide `rs_val` by `rt_val`. LO receives the quotient and HI the remainder. Signed results truncate toward zero, and the remainder takes the sign of the dividend.
- R5: An accepted divide raises `busy` in the next cycle. `busy` stays high for exactly W+1 cycles, and HI and LO hold the divide result once it falls.
- R6: A divisor of zero, signed or unsigned, gives LO = all ones and HI = the original dividend.
- R7: A signed divide of 0x80000000 by 0xFFFFFFFF gives LO = 0x80000000 and HI = 0, with no other effect.
- R8: In the secondary group (`op_alt`=1), function 0x00 (signed) and 0x01 (unsigned) add the 64-bit product to {HI,LO}. Function 0x04 (signed) and 0x05 (unsigned) subtract it. Carries and borrows cross between the two words.
- R9: Secondary function 0x02 puts the low word of the signed product on `mul_lo` with a one-cycle `mul_valid` pulse in the next cycle. HI and LO are left unchanged.
- R10: A read of HI or LO issued while `busy` is high produces no `rd_valid` while busy. It is answered with the post-divide value in the cycle after `busy` falls.
- R11: Writes, multiplies and divides issued while `busy` is high are ignored. Function codes not listed above change neither HI nor LO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Command strobe, one cycle per command |
| op_alt | input | 1 | Group select: 0 primary, 1 secondary |
| op_func | input | 6 | Function code |
| rs_val | input | W | First operand, also the value for moves into HI or LO |
| rt_val | input | W | Second operand |
| busy | output | 1 | A divide is in flight |
| rd_valid | output | 1 | `rd_data` carries a HI or LO read |
| rd_data | output | W | Read data |
| mul_valid | output | 1 | `mul_lo` carries a fresh three-operand product |
| mul_lo | output | W | Low word of the signed product |

## Verification
On every cycle the assertions check the control timing:
- a divide start raises `busy`, and each busy period lasts exactly W+1 cycles;
- `rd_valid` never follows a busy cycle directly;
- every idle read is acknowledged;
- `mul_valid` pulses exactly when a three-operand multiply was accepted;
- reset leaves the handshake outputs low.

Only the directed scenarios can show that the numbers are correct. These are the signed and unsigned products, the sign rules for quotient and remainder, carries across the HI:LO boundary in accumulation, the zero-divisor and most-negative-divided-by-minus-one results, and the fact that commands dropped during a divide leave HI and LO untouched.

// File: rtl/hilo_pkg.sv
package hilo_pkg;

  localparam int FUNC_W = 6;

  // primary group
  localparam logic [FUNC_W-1:0] FN_RD_HI = 6'h10;
  localparam logic [FUNC_W-1:0] FN_WR_HI = 6'h11;
  localparam logic [FUNC_W-1:0] FN_RD_LO = 6'h12;
  localparam logic [FUNC_W-1:0] FN_WR_LO = 6'h13;
  localparam logic [FUNC_W-1:0] FN_MUL_S = 6'h18;
  localparam logic [FUNC_W-1:0] FN_MUL_U = 6'h19;
  localparam logic [FUNC_W-1:0] FN_DIV_S = 6'h1A;
  localparam logic [FUNC_W-1:0] FN_DIV_U = 6'h1B;

  // secondary group
  localparam logic [FUNC_W-1:0] FN_ACC_ADD_S = 6'h00;
  localparam logic [FUNC_W-1:0] FN_ACC_ADD_U = 6'h01;
  localparam logic [FUNC_W-1:0] FN_MUL3      = 6'h02;
  localparam logic [FUNC_W-1:0] FN_ACC_SUB_S = 6'h04;
  localparam logic [FUNC_W-1:0] FN_ACC_SUB_U = 6'h05;

  typedef enum logic [3:0] {
    K_NONE,
    K_RD_HI,
    K_WR_HI,
    K_RD_LO,
    K_WR_LO,
    K_MULT,
    K_DIV,
    K_ACC_ADD,
    K_ACC_SUB,
    K_MUL3
  } cmd_kind_e;

endpackage

// File: rtl/hilo_mul.sv
// Full-width product of two W-bit operands, signed or unsigned.
module hilo_mul #(
  parameter int W = 32
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic           sgn_i,
  output logic [2*W-1:0] prod_o
);
  localparam int PW = 2 * W;

  logic [PW-1:0] a_ext;
  logic [PW-1:0] b_ext;

  always_comb begin
    a_ext = sgn_i ? {{W{a_i[W-1]}}, a_i} : {{W{1'b0}}, a_i};
    b_ext = sgn_i ? {{W{b_i[W-1]}}, b_i} : {{W{1'b0}}, b_i};
    // modulo 2^PW product of the extended operands equals the true product
    prod_o = a_ext * b_ext;
  end
endmodule

// File: rtl/hilo_div.sv
// Restoring divider, one quotient bit per clock, with sign fix-up.
module hilo_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic         sgn_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o
);
  localparam int CW = $clog2(W) + 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic          running_q, done_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  part_q;     // partial remainder
  logic [W-1:0]  shreg_q;    // dividend bits out, quotient bits in
  logic [W-1:0]  dvs_q;
  logic [W-1:0]  orig_q;
  logic          neg_quo_q, neg_rem_q, zero_q;
  logic [W-1:0]  quot_q, rem_q;

  logic [W:0]    shifted, trial;
  logic          take;
  logic [W-1:0]  nxt_part, nxt_shreg;
  logic [W-1:0]  a_mag, b_mag;

  always_comb begin
    a_mag     = (sgn_i && dividend_i[W-1]) ? (~dividend_i + 1'b1) : dividend_i;
    b_mag     = (sgn_i && divisor_i[W-1])  ? (~divisor_i + 1'b1)  : divisor_i;
    shifted   = {part_q, shreg_q[W-1]};
    trial     = shifted - {1'b0, dvs_q};
    take      = ~trial[W];
    nxt_part  = take ? trial[W-1:0] : shifted[W-1:0];
    nxt_shreg = {shreg_q[W-2:0], take};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running_q <= 1'b0;
      done_q    <= 1'b0;
      cnt_q     <= '0;
      part_q    <= '0;
      shreg_q   <= '0;
      dvs_q     <= '0;
      orig_q    <= '0;
      neg_quo_q <= 1'b0;
      neg_rem_q <= 1'b0;
      zero_q    <= 1'b0;
      quot_q    <= '0;
      rem_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !running_q && !done_q) begin
        running_q <= 1'b1;
        cnt_q     <= '0;
        part_q    <= '0;
        shreg_q   <= a_mag;
        dvs_q     <= b_mag;
        orig_q    <= dividend_i;
        neg_quo_q <= sgn_i & (dividend_i[W-1] ^ divisor_i[W-1]);
        neg_rem_q <= sgn_i & dividend_i[W-1];
        zero_q    <= (divisor_i == '0);
      end else if (running_q) begin
        part_q  <= nxt_part;
        shreg_q <= nxt_shreg;
        cnt_q   <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          running_q <= 1'b0;
          done_q    <= 1'b1;
          if (zero_q) begin
            quot_q <= '1;
            rem_q  <= orig_q;
          end else begin
            quot_q <= neg_quo_q ? (~nxt_shreg + 1'b1) : nxt_shreg;
            rem_q  <= neg_rem_q ? (~nxt_part + 1'b1)  : nxt_part;
          end
        end
      end
    end
  end

  assign busy_o = running_q | done_q;
  assign done_o = done_q;
  assign quot_o = quot_q;
  assign rem_o  = rem_q;
endmodule

// File: rtl/hilo_muldiv.sv
module hilo_muldiv
  import hilo_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic              op_alt,
  input  logic [FUNC_W-1:0] op_func,
  input  logic [W-1:0]      rs_val,
  input  logic [W-1:0]      rt_val,
  output logic              busy,
  output logic              rd_valid,
  output logic [W-1:0]      rd_data,
  output logic              mul_valid,
  output logic [W-1:0]      mul_lo
);
  localparam int PW = 2 * W;

  cmd_kind_e     kind;
  logic          kind_sgn;
  logic          accept, is_read;
  logic [PW-1:0] prod, acc_now, acc_add, acc_sub;
  logic          div_busy, div_done;
  logic [W-1:0]  div_quot, div_rem;

  logic [W-1:0]  hi_q, lo_q;
  logic          pend_q, pend_hi_q;

  always_comb begin
    kind     = K_NONE;
    kind_sgn = 1'b0;
    if (!op_alt) begin
      unique case (op_func)
        FN_RD_HI: kind = K_RD_HI;
        FN_WR_HI: kind = K_WR_HI;
        FN_RD_LO: kind = K_RD_LO;
        FN_WR_LO: kind = K_WR_LO;
        FN_MUL_S: begin kind = K_MULT; kind_sgn = 1'b1; end
        FN_MUL_U: kind = K_MULT;
        FN_DIV_S: begin kind = K_DIV; kind_sgn = 1'b1; end
        FN_DIV_U: kind = K_DIV;
        default:  kind = K_NONE;
      endcase
    end else begin
      unique case (op_func)
        FN_ACC_ADD_S: begin kind = K_ACC_ADD; kind_sgn = 1'b1; end
        FN_ACC_ADD_U: kind = K_ACC_ADD;
        FN_MUL3:      begin kind = K_MUL3; kind_sgn = 1'b1; end
        FN_ACC_SUB_S: begin kind = K_ACC_SUB; kind_sgn = 1'b1; end
        FN_ACC_SUB_U: kind = K_ACC_SUB;
        default:      kind = K_NONE;
      endcase
    end
  end

  assign accept  = op_valid && !div_busy;
  assign is_read = (kind == K_RD_HI) || (kind == K_RD_LO);

  hilo_mul #(.W(W)) u_mul (
    .a_i    (rs_val),
    .b_i    (rt_val),
    .sgn_i  (kind_sgn),
    .prod_o (prod)
  );

  hilo_div #(.W(W)) u_div (
    .clk        (clk),
    .rst        (rst),
    .start_i    (accept && (kind == K_DIV)),
    .sgn_i      (kind_sgn),
    .dividend_i (rs_val),
    .divisor_i  (rt_val),
    .busy_o     (div_busy),
    .done_o     (div_done),
    .quot_o     (div_quot),
    .rem_o      (div_rem)
  );

  always_comb begin
    acc_now = {hi_q, lo_q};
    acc_add = acc_now + prod;
    acc_sub = acc_now - prod;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q      <= '0;
      lo_q      <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      mul_valid <= 1'b0;
      mul_lo    <= '0;
      pend_q    <= 1'b0;
      pend_hi_q <= 1'b0;
    end else begin
      rd_valid  <= 1'b0;
      mul_valid <= 1'b0;
      if (div_done) begin
        hi_q <= div_rem;
        lo_q <= div_quot;
      end
      if (accept) begin
        unique case (kind)
          K_RD_HI:   begin rd_data <= hi_q; rd_valid <= 1'b1; end
          K_RD_LO:   begin rd_data <= lo_q; rd_valid <= 1'b1; end
          K_WR_HI:   hi_q <= rs_val;
          K_WR_LO:   lo_q <= rs_val;
          K_MULT:    {hi_q, lo_q} <= prod;
          K_ACC_ADD: {hi_q, lo_q} <= acc_add;
          K_ACC_SUB: {hi_q, lo_q} <= acc_sub;
          K_MUL3:    begin mul_lo <= prod[W-1:0]; mul_valid <= 1'b1; end
          default:   ;
        endcase
      end else if (op_valid && is_read) begin
        pend_q    <= 1'b1;
        pend_hi_q <= (kind == K_RD_HI);
      end
      if (pend_q && !div_busy) begin
        rd_data  <= pend_hi_q ? hi_q : lo_q;
        rd_valid <= 1'b1;
        pend_q   <= 1'b0;
      end
    end
  end

  assign busy = div_busy;
endmodule

// File: rtl/hilo_muldiv_chk.sv
module hilo_muldiv_chk #(
  parameter int W = 32
) (
  input logic       clk,
  input logic       rst,
  input logic       op_valid,
  input logic       op_alt,
  input logic [5:0] op_func,
  input logic       busy,
  input logic       rd_valid,
  input logic       mul_valid
);
  logic        acc_div, acc_mul3, acc_read;
  logic [15:0] run_len;

  assign acc_div  = op_valid && !busy && !op_alt && (op_func == 6'h1A || op_func == 6'h1B);
  assign acc_mul3 = op_valid && !busy && op_alt && (op_func == 6'h02);
  assign acc_read = op_valid && !busy && !op_alt && (op_func == 6'h10 || op_func == 6'h12);

  always_ff @(posedge clk) begin
    if (rst)       run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !rd_valid && !mul_valid));

  assert_read_ack_R2: assert property (@(posedge clk) disable iff (rst)
    acc_read |=> rd_valid);

  assert_div_raises_busy_R5: assert property (@(posedge clk) disable iff (rst)
    acc_div |=> busy);

  assert_busy_length_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run_len == 16'(W + 1)));

  assert_mul3_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    acc_mul3 |=> mul_valid);

  assert_mul3_cause_R9: assert property (@(posedge clk) disable iff (rst)
    mul_valid |-> $past(acc_mul3));

  assert_no_read_while_busy_R10: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !$past(busy));
endmodule

bind hilo_muldiv hilo_muldiv_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .op_valid  (op_valid),
  .op_alt    (op_alt),
  .op_func   (op_func),
  .busy      (busy),
  .rd_valid  (rd_valid),
  .mul_valid (mul_valid)
);

// File: tb/hilo_muldiv_bench.sv
`timescale 1ns/1ps
module hilo_muldiv_bench;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst;
  logic         op_valid;
  logic         op_alt;
  logic [5:0]   op_func;
  logic [W-1:0] rs_val, rt_val;
  logic         busy, rd_valid, mul_valid;
  logic [W-1:0] rd_data, mul_lo;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  hilo_muldiv #(.W(W)) u_hilo_muldiv (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_alt(op_alt),
    .op_func(op_func), .rs_val(rs_val), .rt_val(rt_val), .busy(busy),
    .rd_valid(rd_valid), .rd_data(rd_data), .mul_valid(mul_valid), .mul_lo(mul_lo)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one command for one clock; returns at the following negedge
  task automatic cmd(input bit alt, input logic [5:0] f,
                     input logic [W-1:0] a, input logic [W-1:0] b);
    op_valid = 1'b1; op_alt = alt; op_func = f; rs_val = a; rt_val = b;
    @(negedge clk);
    op_valid = 1'b0; op_alt = 1'b0; op_func = '0; rs_val = '0; rt_val = '0;
  endtask

  task automatic rd(input bit sel_hi, output logic [W-1:0] v);
    cmd(1'b0, sel_hi ? 6'h10 : 6'h12, '0, '0);
    v = rd_valid ? rd_data : 'x;
  endtask

  task automatic expect_hilo(input string tag, input logic [W-1:0] eh, input logic [W-1:0] el);
    logic [W-1:0] h, l;
    rd(1'b1, h);
    rd(1'b0, l);
    chk(tag, {h, l}, {eh, el});
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic set_hilo(input logic [W-1:0] h, input logic [W-1:0] l);
    cmd(1'b0, 6'h11, h, '0);
    cmd(1'b0, 6'h13, l, '0);
  endtask

  task automatic t_reset();
    chk("R1 handshake outputs", {61'd0, busy, rd_valid, mul_valid}, 64'd0);
    expect_hilo("R1 HI/LO zero", '0, '0);
  endtask

  task automatic t_moves();
    set_hilo(32'hCAFE_0001, 32'h1234_5678);
    cmd(1'b0, 6'h10, '0, '0);
    chk("R2 rd_valid after HI read", {63'd0, rd_valid}, 64'd1);
    chk("R2 HI data", {32'd0, rd_data}, {32'd0, 32'hCAFE_0001});
    expect_hilo("R2 both words", 32'hCAFE_0001, 32'h1234_5678);
  endtask

  task automatic t_mult();
    logic [W-1:0] as [4] = '{32'd7, 32'hFFFF_FFFD, 32'h8000_0000, 32'hFFFF_FFFF};
    logic [W-1:0] bs [4] = '{32'd9, 32'd1000, 32'h8000_0000, 32'hFFFF_FFFF};
    for (int i = 0; i < 4; i++) begin
      logic [63:0] ps, pu;
      ps = longint'($signed(as[i])) * longint'($signed(bs[i]));
      pu = {32'd0, as[i]} * {32'd0, bs[i]};
      cmd(1'b0, 6'h18, as[i], bs[i]);
      expect_hilo("R3 signed multiply", ps[63:32], ps[31:0]);
      cmd(1'b0, 6'h19, as[i], bs[i]);
      expect_hilo("R3 unsigned multiply", pu[63:32], pu[31:0]);
    end
  endtask

  task automatic do_div(input string tag, input bit sgn, input logic [W-1:0] a,
                        input logic [W-1:0] b, input logic [W-1:0] eh, input logic [W-1:0] el);
    cmd(1'b0, sgn ? 6'h1A : 6'h1B, a, b);
    wait_idle();
    expect_hilo(tag, eh, el);
  endtask

  task automatic t_div();
    int sa [4] = '{100, -100, 100, -100};
    int sb [4] = '{7, 7, -7, -7};
    int n;
    for (int i = 0; i < 4; i++)
      do_div("R4 signed divide", 1'b1, sa[i], sb[i], sa[i] % sb[i], sa[i] / sb[i]);
    do_div("R4 unsigned divide", 1'b0, 32'hFFFF_FFF0, 32'd3,
           32'hFFFF_FFF0 % 32'd3, 32'hFFFF_FFF0 / 32'd3);
    // busy length
    cmd(1'b0, 6'h1B, 32'd1000, 32'd10);
    n = 0;
    while (busy && n < 1000) begin @(negedge clk); n++; end
    chk("R5 busy cycles", 64'(n), 64'(W + 1));
    expect_hilo("R5 result at busy fall", 32'd0, 32'd100);
  endtask

  task automatic t_div_zero();
    do_div("R6 signed by zero", 1'b1, 32'd1234, 32'd0, 32'd1234, 32'hFFFF_FFFF);
    do_div("R6 negative by zero", 1'b1, 32'hFFFF_FFFB, 32'd0, 32'hFFFF_FFFB, 32'hFFFF_FFFF);
    do_div("R6 unsigned by zero", 1'b0, 32'h9000_0001, 32'd0, 32'h9000_0001, 32'hFFFF_FFFF);
  endtask

  task automatic t_min_int();
    do_div("R7 most negative by -1", 1'b1, 32'h8000_0000, 32'hFFFF_FFFF, 32'd0, 32'h8000_0000);
  endtask

  task automatic t_acc();
    logic [63:0] m;
    set_hilo(32'd0, 32'hFFFF_FFFF);
    cmd(1'b1, 6'h01, 32'd1, 32'd1);
    expect_hilo("R8 unsigned add carry", 32'd1, 32'd0);
    cmd(1'b1, 6'h00, 32'hFFFF_FFFE, 32'd3);
    m = 64'h0000_0001_0000_0000 - 64'd6;
    expect_hilo("R8 signed add of negative product", m[63:32], m[31:0]);
    cmd(1'b1, 6'h04, 32'hFFFF_FFFF, 32'd2);
    m = m + 64'd2;
    expect_hilo("R8 signed subtract", m[63:32], m[31:0]);
    set_hilo(32'd0, 32'd5);
    cmd(1'b1, 6'h05, 32'hFFFF_FFFF, 32'd2);
    m = 64'd5 - 64'h0000_0001_FFFF_FFFE;
    expect_hilo("R8 unsigned subtract borrow", m[63:32], m[31:0]);
  endtask

  task automatic t_mul3();
    set_hilo(32'hAAAA_0000, 32'h0000_5555);
    cmd(1'b1, 6'h02, 32'hFFFF_FFFD, 32'd5);
    chk("R9 mul_valid pulse", {63'd0, mul_valid}, 64'd1);
    chk("R9 low product", {32'd0, mul_lo}, {32'd0, 32'hFFFF_FFF1});
    @(negedge clk);
    chk("R9 pulse one cycle", {63'd0, mul_valid}, 64'd0);
    expect_hilo("R9 HI/LO untouched", 32'hAAAA_0000, 32'h0000_5555);
  endtask

  task automatic t_busy_hold();
    int n;
    cmd(1'b0, 6'h1A, 32'd100, 32'd7);
    cmd(1'b0, 6'h10, '0, '0);
    chk("R10 no ack while busy", {63'd0, rd_valid}, 64'd0);
    cmd(1'b0, 6'h13, 32'hDEAD_BEEF, '0);
    cmd(1'b0, 6'h18, 32'd3, 32'd3);
    n = 0;
    while (busy && n < 1000) begin
      chk("R10 rd_valid low during busy", {63'd0, rd_valid}, 64'd0);
      @(negedge clk); n++;
    end
    @(negedge clk);
    chk("R10 held read answered", {63'd0, rd_valid}, 64'd1);
    chk("R10 held read data", {32'd0, rd_data}, 64'd2);
    expect_hilo("R11 busy commands dropped", 32'd2, 32'd14);
    cmd(1'b0, 6'h15, 32'h1111_1111, 32'h2222_2222);
    cmd(1'b1, 6'h07, 32'h1111_1111, 32'h2222_2222);
    expect_hilo("R11 undefined codes inert", 32'd2, 32'd14);
  endtask

  initial begin
    op_valid = 1'b0; op_alt = 1'b0; op_func = '0; rs_val = '0; rt_val = '0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_moves();
    t_mult();
    t_div();
    t_div_zero();
    t_min_int();
    t_acc();
    t_mul3();
    t_busy_hold();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired before all scenarios ended");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule